// File: doc/BRIEF.md
# Multi-Chip Serial Readout Merger

This block sits between a group of front-end sensor chips and a link serializer. Each chip drives one or two serial lines, one bit per clock on a shared serializer clock. For every line the block recovers 20-bit word boundaries by hunting for a fixed alignment pattern. It discards those alignment words, keeps the payload words, and tags each one with the number of the chip that produced it.

Every line feeds a small word FIFO. A round-robin arbiter drains the non-empty FIFOs at one word per clock into a single tagged parallel stream with a valid strobe. If a line's FIFO cannot take a word, the word is dropped and a sticky per-line error flag is raised. A clear input resets the flags.

Top module: `serial_readout_merger`

## Requirements
- R1: Each line `ser_in[l]` is deserialized most-significant bit first, one bit per clock, into 20-bit words.
- R2: A line locks only after three alignment words (20'hAAAAA) in a row, each 20 bits after the last. Until it is locked, no word from that line reaches the output, and this also holds when a relock attempt sees only two alignment words.
- R3: Alignment words are never forwarded. An idle stream made only of alignment words produces no output.
- R4: While locked, a word with bits [19:18] = 2'b11 is a data word. Any other word that is not an alignment word is invalid and is dropped. One invalid word leaves the lock in place. Two invalid words in a row drop the lock.
- R5: An output word is 26 bits: bits [25:20] hold the chip ID and bits [19:0] hold the data word. The chip ID of line l is l / LINES_PER_CHIP.
- R6: When no FIFO overflows, every data word of a locked line appears on the output exactly once, in the order the line sent it.
- R7: The arbiter grants one non-empty FIFO per clock in rotating order. When all N lines deliver a word in the same cycle into empty FIFOs, `out_valid` is high for exactly N consecutive cycles.
- R8: A data word that arrives at a full FIFO with no read in the same cycle is dropped. It sets `ovf_err[l]`, which then stays high.
- R9: A one-cycle pulse on `err_clr` clears all error flags. An overflow in the same cycle as the clear wins, so a flag can rise while `err_clr` is held high.
- R10: While reset is low, and after it, `out_valid` and `ovf_err` are all zero and every line is hunting for alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serializer clock, one bit per line per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | N_CHIPS*LINES_PER_CHIP | Serial bit of each line, line l at bit l |
| err_clr | input | 1 | Clears all sticky overflow flags |
| out_valid | output | 1 | Output word is valid this cycle |
| out_word | output | ID_W+20 | Chip ID above the 20-bit data word |
| ovf_err | output | N_CHIPS*LINES_PER_CHIP | Sticky FIFO overflow flag per line |

## Verification
Two events can land on the same flag in the same cycle: a FIFO overflow setting it and `err_clr` clearing it. The bench provokes this by holding `err_clr` high while all lines stream data words in step, which grows FIFO backlog until words are dropped. It passes only if some flag is seen high while the clear is still asserted, and the flags read zero once the clear is released and pulsed again. A second collision is a write and a read on a full FIFO in the same cycle. The same in-step bursts exercise it, and the bench judges it through the per-line order check on the output stream.

// File: rtl/smrg_pkg.sv
package smrg_pkg;
    localparam int               MRG_WORD_W     = 20;
    localparam logic [19:0]      MRG_SYNC       = 20'hAAAAA;
    localparam logic [1:0]       MRG_HDR        = 2'b11;
    localparam int               MRG_LOCK_SYNCS = 3;
    localparam int               MRG_UNLOCK_BAD = 2;
    localparam int               MRG_ID_W       = 6;
    localparam int               MRG_FIFO_DEPTH = 4;

    typedef enum logic [1:0] {
        AL_HUNT   = 2'd0,
        AL_VERIFY = 2'd1,
        AL_LOCK   = 2'd2
    } align_st_e;
endpackage

// File: rtl/smrg_line_align.sv
module smrg_line_align #(
    parameter int                WORD_W     = smrg_pkg::MRG_WORD_W,
    parameter logic [WORD_W-1:0] SYNC_PAT   = smrg_pkg::MRG_SYNC,
    parameter logic [1:0]        HDR_PAT    = smrg_pkg::MRG_HDR,
    parameter int                LOCK_SYNCS = smrg_pkg::MRG_LOCK_SYNCS,
    parameter int                UNLOCK_BAD = smrg_pkg::MRG_UNLOCK_BAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int CNT_MAX = (LOCK_SYNCS > UNLOCK_BAD) ? LOCK_SYNCS : UNLOCK_BAD;
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        smrg_pkg::align_st_e st;
        logic [WORD_W-1:0]   shreg;
        logic [POS_W-1:0]    pos;
        logic [CNT_W-1:0]    cnt;
        logic                vld;
        logic [WORD_W-1:0]   word;
    } al_st_t;

    al_st_t al_d, al_q;
    logic [WORD_W-1:0] win;
    logic              at_edge;

    always_comb begin
        al_d     = al_q;
        al_d.vld = 1'b0;
        win      = {al_q.shreg[WORD_W-2:0], ser_i};
        at_edge  = (al_q.pos == POS_W'(WORD_W - 1));
        al_d.shreg = win;
        al_d.pos   = at_edge ? '0 : al_q.pos + 1'b1;
        unique case (al_q.st)
            smrg_pkg::AL_HUNT: begin
                if (win == SYNC_PAT) begin
                    al_d.st  = smrg_pkg::AL_VERIFY;
                    al_d.cnt = CNT_W'(1);
                    al_d.pos = '0;
                end
            end
            smrg_pkg::AL_VERIFY: begin
                if (at_edge) begin
                    if (win == SYNC_PAT) begin
                        if (al_q.cnt == CNT_W'(LOCK_SYNCS - 1)) begin
                            al_d.st  = smrg_pkg::AL_LOCK;
                            al_d.cnt = '0;
                        end else begin
                            al_d.cnt = al_q.cnt + 1'b1;
                        end
                    end else begin
                        al_d.st  = smrg_pkg::AL_HUNT;
                        al_d.cnt = '0;
                    end
                end
            end
            smrg_pkg::AL_LOCK: begin
                if (at_edge) begin
                    if (win == SYNC_PAT) begin
                        al_d.cnt = '0;
                    end else if (win[WORD_W-1 -: 2] == HDR_PAT) begin
                        al_d.cnt  = '0;
                        al_d.vld  = 1'b1;
                        al_d.word = win;
                    end else if (al_q.cnt == CNT_W'(UNLOCK_BAD - 1)) begin
                        al_d.st  = smrg_pkg::AL_HUNT;
                        al_d.cnt = '0;
                    end else begin
                        al_d.cnt = al_q.cnt + 1'b1;
                    end
                end
            end
            default: al_d.st = smrg_pkg::AL_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '{st: smrg_pkg::AL_HUNT, shreg: '0, pos: '0, cnt: '0, vld: 1'b0, word: '0};
        end else begin
            al_q <= al_d;
        end
    end

    assign word_vld_o = al_q.vld;
    assign word_o     = al_q.word;

    // R2: a word leaves only if the line was locked when it completed
    p_fwd_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        al_q.vld |-> $past(al_q.st == smrg_pkg::AL_LOCK));
    // R3: the alignment pattern never leaves the line
    p_no_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        al_q.vld |-> (al_q.word != SYNC_PAT));
    // R4: a locked line only changes state on a word boundary
    p_lock_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q.st == smrg_pkg::AL_LOCK && !at_edge) |=> (al_q.st == smrg_pkg::AL_LOCK));
endmodule

// File: rtl/smrg_word_fifo.sv
module smrg_word_fifo #(
    parameter int DW    = smrg_pkg::MRG_WORD_W,
    parameter int DEPTH = smrg_pkg::MRG_FIFO_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    input  logic          clr_i,
    output logic [DW-1:0] data_o,
    output logic          empty_o,
    output logic          err_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     err;
    } fifo_st_t;

    fifo_st_t ff_d, ff_q;
    logic full, do_pop, do_push;

    always_comb begin
        ff_d    = ff_q;
        full    = (ff_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && (ff_q.cnt != '0);
        do_push = push_i && (!full || do_pop);
        if (do_push) begin
            ff_d.mem[ff_q.wp] = data_i;
            ff_d.wp = (ff_q.wp == AW'(DEPTH - 1)) ? '0 : ff_q.wp + 1'b1;
        end
        if (do_pop) begin
            ff_d.rp = (ff_q.rp == AW'(DEPTH - 1)) ? '0 : ff_q.rp + 1'b1;
        end
        ff_d.cnt = ff_q.cnt + CW'(do_push) - CW'(do_pop);
        if (push_i && !do_push) begin
            ff_d.err = 1'b1;
        end else if (clr_i) begin
            ff_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

    assign data_o  = ff_q.mem[ff_q.rp];
    assign empty_o = (ff_q.cnt == '0);
    assign err_o   = ff_q.err;

    // R7: the arbiter never reads an empty FIFO
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    // R8: a refused word raises the flag on the next cycle
    p_ovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> err_o);
    // R8: the fill level stays within the storage
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ff_q.cnt <= CW'(DEPTH));
    // R9: without a clear the flag holds
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/smrg_rr_arb.sv
module smrg_rr_arb #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } arb_st_t;

    arb_st_t arb_d, arb_q;
    logic    found;
    int      idx;

    always_comb begin
        arb_d = arb_q;
        gnt_o = '0;
        found = 1'b0;
        idx   = 0;
        for (int i = 0; i < N; i++) begin
            idx = int'(arb_q.ptr) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req_i[idx]) begin
                found      = 1'b1;
                gnt_o[idx] = 1'b1;
                arb_d.ptr  = (idx == N - 1) ? '0 : PTR_W'(idx + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    // R7: at most one line is served per clock
    p_gnt_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R7: only a requesting line is served
    p_gnt_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |-> ((gnt_o & ~req_i) == '0));
    // R7: no clock is wasted while any line waits
    p_work_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/serial_readout_merger.sv
module serial_readout_merger #(
    parameter int N_CHIPS        = 8,
    parameter int LINES_PER_CHIP = 2,
    parameter int WORD_W         = smrg_pkg::MRG_WORD_W,
    parameter int ID_W           = smrg_pkg::MRG_ID_W,
    parameter int FIFO_DEPTH     = smrg_pkg::MRG_FIFO_DEPTH
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_CHIPS*LINES_PER_CHIP-1:0]    ser_in,
    input  logic                                 err_clr,
    output logic                                 out_valid,
    output logic [ID_W+WORD_W-1:0]               out_word,
    output logic [N_CHIPS*LINES_PER_CHIP-1:0]    ovf_err
);
    localparam int NL    = N_CHIPS * LINES_PER_CHIP;
    localparam int OUT_W = ID_W + WORD_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] word;
    } out_st_t;

    logic [NL-1:0]     line_vld;
    logic [WORD_W-1:0] line_word [NL];
    logic [WORD_W-1:0] fifo_data [NL];
    logic [NL-1:0]     fifo_empty;
    logic [NL-1:0]     gnt;
    logic [NL-1:0]     req;

    for (genvar l = 0; l < NL; l++) begin : g_line
        smrg_line_align #(
            .WORD_W (WORD_W)
        ) u_align (
            .clk        (clk),
            .rst_n      (rst_n),
            .ser_i      (ser_in[l]),
            .word_vld_o (line_vld[l]),
            .word_o     (line_word[l])
        );

        smrg_word_fifo #(
            .DW    (WORD_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (line_vld[l]),
            .data_i  (line_word[l]),
            .pop_i   (gnt[l]),
            .clr_i   (err_clr),
            .data_o  (fifo_data[l]),
            .empty_o (fifo_empty[l]),
            .err_o   (ovf_err[l])
        );
    end

    assign req = ~fifo_empty;

    smrg_rr_arb #(
        .N (NL)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    out_st_t          o_d, o_q;
    logic [OUT_W-1:0] sel;

    always_comb begin
        o_d     = o_q;
        o_d.vld = |gnt;
        sel     = '0;
        for (int l = 0; l < NL; l++) begin
            if (gnt[l]) sel = {ID_W'(l / LINES_PER_CHIP), fifo_data[l]};
        end
        if (|gnt) o_d.word = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_word  = o_q.word;

    // R7: a grant yields an output word on the next clock
    p_out_after_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> out_valid);
    // R5: the tag always names an existing chip
    p_chip_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_word[OUT_W-1 -: ID_W]) < N_CHIPS));
endmodule

// File: tb/tb_serial_readout_merger.sv
module tb_serial_readout_merger;
    localparam int NC  = 12;
    localparam int LPC = 2;
    localparam int NL  = NC * LPC;
    localparam logic [19:0] SYNC = 20'hAAAAA;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   ser = '0;
    logic            err_clr = 1'b0;
    logic            out_valid;
    logic [25:0]     out_word;
    logic [NL-1:0]   ovf_err;

    always #5 clk = ~clk;

    serial_readout_merger #(
        .N_CHIPS        (NC),
        .LINES_PER_CHIP (LPC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser),
        .err_clr   (err_clr),
        .out_valid (out_valid),
        .out_word  (out_word),
        .ovf_err   (ovf_err)
    );

    int tests = 0;
    int fails = 0;
    logic [19:0] wq    [NL][$];
    logic [19:0] exp_q [NL][$];
    logic [19:0] cur_w [NL];
    int  bitp = 0;
    int  out_cnt = 0;
    int  line_cnt [NL];
    int  run_len = 0;
    int  max_run = 0;
    bit  lenient = 1'b0;
    bit  seen_err_in_clr = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] mk_word(input int line, input int seq);
        return {2'b11, 5'(line), 13'(seq)};
    endfunction

    task automatic send(input int l, input logic [19:0] w, input bit expect_out);
        wq[l].push_back(w);
        if (expect_out) exp_q[l].push_back(w);
    endtask

    task automatic wait_words(input int n);
        repeat (n * 20) @(negedge clk);
    endtask

    // serial driver: whole words per line, all lines in step, MSB first (R1)
    always @(negedge clk) begin
        if (!rst_n) begin
            bitp = 0;
            ser  = '0;
        end else begin
            if (bitp == 0) begin
                for (int l = 0; l < NL; l++)
                    cur_w[l] = (wq[l].size() > 0) ? wq[l].pop_front() : SYNC;
            end
            for (int l = 0; l < NL; l++) ser[l] = cur_w[l][19 - bitp];
            bitp = (bitp == 19) ? 0 : bitp + 1;
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_clr && (ovf_err != '0)) seen_err_in_clr = 1'b1;
            if (out_valid) begin
                int ln;
                logic [19:0] w;
                run_len++;
                if (run_len > max_run) max_run = run_len;
                out_cnt++;
                w  = out_word[19:0];
                ln = int'(w[17:13]);
                if (ln >= NL) begin
                    chk(1'b0, "R2", "word from an unlocked line", w, 0);
                end else begin
                    line_cnt[ln]++;
                    chk(int'(out_word[25:20]) == ln / LPC, "R5", "chip id",
                        out_word[25:20], ln / LPC);
                    if (lenient) begin
                        int pos = -1;
                        for (int i = 0; i < exp_q[ln].size(); i++)
                            if (pos < 0 && exp_q[ln][i] == w) pos = i;
                        chk(pos >= 0, "R6", "out-of-order word under overflow", w, 0);
                        if (pos >= 0) for (int i = 0; i <= pos; i++) void'(exp_q[ln].pop_front());
                    end else if (exp_q[ln].size() == 0) begin
                        chk(1'b0, "R6", "unexpected word", w, 0);
                    end else begin
                        logic [19:0] e;
                        e = exp_q[ln].pop_front();
                        chk(w == e, "R6", "word order", w, e);
                    end
                end
            end else begin
                run_len = 0;
            end
        end
    end

    function automatic int pending();
        int n = 0;
        for (int l = 0; l < NL; l++) n += exp_q[l].size();
        return n;
    endfunction

    initial begin
        #(150000 * 10);
        fails++;
        $display("FAIL watchdog timeout act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int l = 0; l < NL; l++) line_cnt[l] = 0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
        chk(ovf_err == '0, "R10", "ovf_err in reset", ovf_err, 0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

        // R3: idle alignment stream gives nothing
        wait_words(6);
        chk(out_cnt == 0, "R3", "words out of idle stream", out_cnt, 0);

        // R1: directed words on line 0
        send(0, mk_word(0, 13'h1A5A), 1);
        send(0, mk_word(0, 13'h0001), 1);
        send(0, mk_word(0, 13'h1FFE), 1);
        wait_words(5);
        chk(line_cnt[0] == 3, "R1", "words from line 0", line_cnt[0], 3);
        chk(exp_q[0].size() == 0, "R1", "line 0 words pending", exp_q[0].size(), 0);

        // R7: all lines at once into empty FIFOs
        max_run = 0;
        for (int l = 0; l < NL; l++) send(l, mk_word(l, 100 + l), 1);
        wait_words(4);
        chk(max_run == NL, "R7", "consecutive valid cycles", max_run, NL);
        chk(pending() == 0, "R7", "burst words pending", pending(), 0);

        // R6: constrained random traffic, 40% word density
        for (int b = 0; b < 300; b++) begin
            for (int l = 0; l < NL; l++) begin
                if ($urandom_range(99) < 40) send(l, mk_word(l, $urandom_range(8191)), 1);
                else send(l, SYNC, 0);
            end
        end
        wait_words(306);
        chk(pending() == 0, "R6", "random words pending", pending(), 0);
        chk(ovf_err == '0, "R8", "no overflow at low load", ovf_err, 0);

        // R4 and R2: invalid words and lock loss on line 3
        line_cnt[3] = 0;
        send(3, mk_word(3, 1), 1);
        send(3, 20'h00000, 0);
        send(3, mk_word(3, 2), 1);
        send(3, 20'h00000, 0);
        send(3, mk_word(3, 3), 1);
        send(3, 20'h00000, 0);
        send(3, 20'h00000, 0);
        send(3, 20'hFFFFF, 0);
        send(3, SYNC, 0);
        send(3, SYNC, 0);
        send(3, 20'hFFFFF, 0);
        send(3, SYNC, 0);
        send(3, SYNC, 0);
        send(3, SYNC, 0);
        send(3, mk_word(3, 4), 1);
        wait_words(20);
        chk(line_cnt[3] == 4, "R4", "line 3 words kept", line_cnt[3], 4);
        chk(exp_q[3].size() == 0, "R2", "line 3 relock words pending", exp_q[3].size(), 0);
        chk(out_cnt > 0, "R2", "stream alive", out_cnt, 1);

        // R8: overflow by in-step saturation
        lenient = 1'b1;
        for (int b = 0; b < 60; b++)
            for (int l = 0; l < NL; l++) send(l, mk_word(l, 2000 + b), 1);
        wait_words(72);
        chk(ovf_err != '0, "R8", "overflow flag raised", ovf_err, 1);
        begin
            logic [NL-1:0] snap;
            snap = ovf_err;
            wait_words(3);
            chk(ovf_err == snap, "R8", "flag sticky", ovf_err, snap);
        end
        // R9: single-cycle clear
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(ovf_err == '0, "R9", "flags after clear", ovf_err, 0);

        // R9: overflow during a held clear must still show
        seen_err_in_clr = 1'b0;
        err_clr = 1'b1;
        for (int b = 0; b < 60; b++)
            for (int l = 0; l < NL; l++) send(l, mk_word(l, 4000 + b), 1);
        wait_words(64);
        chk(seen_err_in_clr == 1'b1, "R9", "overflow wins over clear", seen_err_in_clr, 1);
        err_clr = 1'b0;
        wait_words(10);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(ovf_err == '0, "R9", "flags after final clear", ovf_err, 0);
        for (int l = 0; l < NL; l++) exp_q[l].delete();
        lenient = 1'b0;

        // R6: strict order again after recovery
        send(5, mk_word(5, 77), 1);
        send(17, mk_word(17, 78), 1);
        wait_words(4);
        chk(pending() == 0, "R6", "words after recovery", pending(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule